// File: doc/BRIEF.md
# PPS Frequency Calibration Unit

This block estimates the frequency error of a free-running local counter by comparing counter snapshots taken at successive pulse-per-second edges. A calibration interval spans a power-of-two number of pulses, so the average ticks per second is the wrapped counter difference shifted right by the interval exponent, with no divider. The nominal tick count per second is subtracted from that quotient to give the measured error. The difference between the measured error and the current estimate is clamped, and the clamped value is added to the running estimate.

Each pulse is screened before it counts toward an interval. A spacing outside the allowed window shows that a pulse was lost or a spurious one arrived. In that case the pulse count no longer equals a power of two seconds, so the interval is thrown away. A finished interval whose error lies outside the valid range is also thrown away. Both cases restart calibration at the shortest interval. An accepted measurement doubles the next interval, up to a programmable ceiling. An enable input decides whether the estimate reaches the clock-steering output. The estimate itself is updated whether or not that input is set.

Top module: `pps_freq_cal`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, every output is zero.
- R2: The first `pulse_vld` after reset only records the sample and starts an interval of 4 pulses. No output changes apart from `status` being zero.
- R3: An interval with exponent k closes on the 2^k-th valid pulse after its start. The measured error is ((end − start) mod 2^CNT_W) >> k minus NOM_TICKS, so counter rollover is handled.
- R4: After an accepted measurement the exponent becomes min(k+1, cap). The cap is `max_exp` limited to the range [2, MAX_EXP]. After any error the exponent returns to 2 and the new interval starts at the current pulse.
- R5: If the spacing of a pulse from the previous one, modulo 2^CNT_W, falls outside NOM_TICKS ± GAP_TOL, then `status` bit 0 is set, `err_cnt` increments, and the interval is discarded.
- R6: If a closing interval's measured error has magnitude above RANGE_TICKS, then `status` bit 1 is set, `err_cnt` increments, and `pps_freq` and `wander_stat` are left unchanged.
- R7: On acceptance, the step (measured − `pps_freq`) is clamped to ±STEP_MAX and added to `pps_freq`. A clamped step sets `status` bit 2 and increments `wander_cnt`.
- R8: On acceptance, with a = |clamped step| and w = `wander_stat`, w becomes w + ((a − w) >> 2) if a ≥ w, and w − ((w − a) >> 2) otherwise.
- R9: `clk_freq` equals the `pps_freq` of the previous cycle when `freq_en` was high in that cycle, and is zero otherwise.
- R10: `status` shows the outcome of the most recent pulse only. A pulse with no error and no clamp clears it, and it holds between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_vld | input | 1 | One-cycle strobe per captured PPS edge |
| cnt_sample | input | CNT_W | Counter snapshot belonging to the strobe |
| max_exp | input | EXP_W | Ceiling for the interval exponent |
| freq_en | input | 1 | Lets the estimate drive `clk_freq` |
| pps_freq | output | FREQ_W | Signed frequency error estimate, ticks per second |
| clk_freq | output | FREQ_W | Signed steering value for the clock |
| wander_stat | output | WND_W | Averaged magnitude of accepted steps |
| status | output | 3 | bit0 spacing error, bit1 range error, bit2 step clamped |
| err_cnt | output | CTR_W | Wrapping count of discarded measurements |
| wander_cnt | output | CTR_W | Wrapping count of clamped steps |

## Verification
A wrong start sample or exponent shows up as an incorrect `pps_freq` or a spurious range error. This appears on the pulse that closes the interval, which can be up to 2^MAX_EXP pulses after the fault. A wrong pulse count moves the closing pulse, so the estimate changes one or more pulses too early or too late. A bad spacing comparison or a bad clamp shows up in `status` and the counters on the same pulse. The reference model tracks every pulse, so any of these faults is caught at the first pulse where the outputs differ from the model.

// File: rtl/pps_cal_pkg.sv
package pps_cal_pkg;
  localparam int ST_GAP = 0;
  localparam int ST_RNG = 1;
  localparam int ST_CLP = 2;
  localparam int ST_W   = 3;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_ARM,
    EV_COUNT,
    EV_GAP_ERR,
    EV_CLOSE
  } pulse_ev_t;
endpackage

// File: rtl/pps_gap_check.sv
module pps_gap_check #(
  parameter int CNT_W     = 16,
  parameter int NOM_TICKS = 1000,
  parameter int GAP_TOL   = 100
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] prev,
  output logic             gap_ok
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(NOM_TICKS - GAP_TOL);
  localparam logic [CNT_W-1:0] HI = CNT_W'(NOM_TICKS + GAP_TOL);

  logic [CNT_W-1:0] gap;

  // modulo subtraction absorbs counter wrap
  assign gap    = cur - prev;
  assign gap_ok = (gap >= LO) && (gap <= HI);
endmodule

// File: rtl/pps_interval_ctl.sv
module pps_interval_ctl
  import pps_cal_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int EXP_W   = 3,
  parameter int MIN_EXP = 2,
  parameter int MAX_EXP = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_vld,
  input  logic [CNT_W-1:0] sample,
  input  logic             gap_ok,
  input  logic             accept,
  input  logic [EXP_W-1:0] max_exp,
  output pulse_ev_t        ev,
  output logic [EXP_W-1:0] exp_q,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] prev_q
);
  localparam int CW = MAX_EXP + 1;
  localparam logic [EXP_W-1:0] MINE = EXP_W'(MIN_EXP);
  localparam logic [EXP_W-1:0] MAXE = EXP_W'(MAX_EXP);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] len;
  logic [EXP_W-1:0] cap;
  logic [EXP_W-1:0] exp_nxt;

  assign cnt_inc = cnt_q + CW'(1);
  assign len     = CW'(1) << exp_q;

  always_comb begin
    if (max_exp < MINE)      cap = MINE;
    else if (max_exp > MAXE) cap = MAXE;
    else                     cap = max_exp;
    exp_nxt = (exp_q >= cap) ? cap : exp_q + EXP_W'(1);
  end

  always_comb begin
    if (!pulse_vld)        ev = EV_IDLE;
    else if (!armed_q)     ev = EV_ARM;
    else if (!gap_ok)      ev = EV_GAP_ERR;
    else if (cnt_inc == len) ev = EV_CLOSE;
    else                   ev = EV_COUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      exp_q   <= MINE;
      start_q <= '0;
      prev_q  <= '0;
    end else begin
      unique case (ev)
        EV_ARM, EV_GAP_ERR: begin
          armed_q <= 1'b1;
          prev_q  <= sample;
          start_q <= sample;
          cnt_q   <= '0;
          exp_q   <= MINE;
        end
        EV_COUNT: begin
          prev_q <= sample;
          cnt_q  <= cnt_inc;
        end
        EV_CLOSE: begin
          prev_q  <= sample;
          start_q <= sample;
          cnt_q   <= '0;
          exp_q   <= accept ? exp_nxt : MINE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pps_freq_step.sv
module pps_freq_step #(
  parameter int CNT_W       = 16,
  parameter int EXP_W       = 3,
  parameter int FREQ_W      = 16,
  parameter int WND_W       = 8,
  parameter int NOM_TICKS   = 1000,
  parameter int RANGE_TICKS = 50,
  parameter int STEP_MAX    = 10
) (
  input  logic [CNT_W-1:0]         diff,
  input  logic [EXP_W-1:0]         exp_k,
  input  logic signed [FREQ_W-1:0] freq,
  input  logic [WND_W-1:0]         wander,
  output logic                     in_range,
  output logic                     clamped,
  output logic signed [FREQ_W-1:0] freq_nxt,
  output logic [WND_W-1:0]         wander_nxt
);
  localparam int AW = ((CNT_W > FREQ_W) ? CNT_W : FREQ_W) + 3;
  localparam logic signed [AW-1:0] NOM_S = AW'(NOM_TICKS);
  localparam logic signed [AW-1:0] RNG_S = AW'(RANGE_TICKS);
  localparam logic signed [AW-1:0] CLP_S = AW'(STEP_MAX);

  logic [CNT_W-1:0]       quo;
  logic signed [AW-1:0]   meas;
  logic signed [AW-1:0]   step;
  logic signed [AW-1:0]   step_c;
  logic [WND_W-1:0]       mag;

  // power-of-two interval: the division is a shift
  assign quo  = diff >> exp_k;
  assign meas = $signed({{(AW-CNT_W){1'b0}}, quo}) - NOM_S;
  assign in_range = (meas <= RNG_S) && (meas >= -RNG_S);
  assign step = meas - $signed({{(AW-FREQ_W){freq[FREQ_W-1]}}, freq});

  always_comb begin
    clamped = 1'b1;
    if (step > CLP_S)       step_c = CLP_S;
    else if (step < -CLP_S) step_c = -CLP_S;
    else begin
      step_c  = step;
      clamped = 1'b0;
    end
  end

  assign freq_nxt = freq + FREQ_W'(step_c);
  assign mag = step_c[AW-1] ? WND_W'(-step_c) : WND_W'(step_c);

  always_comb begin
    if (mag >= wander) wander_nxt = wander + ((mag - wander) >> 2);
    else               wander_nxt = wander - ((wander - mag) >> 2);
  end
endmodule

// File: rtl/pps_freq_cal.sv
module pps_freq_cal
  import pps_cal_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FREQ_W      = 16,
  parameter int WND_W       = 8,
  parameter int CTR_W       = 8,
  parameter int NOM_TICKS   = 1000,
  parameter int GAP_TOL     = 100,
  parameter int RANGE_TICKS = 50,
  parameter int STEP_MAX    = 10,
  parameter int MAX_EXP     = 5,
  parameter int EXP_W       = $clog2(MAX_EXP + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pulse_vld,
  input  logic [CNT_W-1:0]         cnt_sample,
  input  logic [EXP_W-1:0]         max_exp,
  input  logic                     freq_en,
  output logic signed [FREQ_W-1:0] pps_freq,
  output logic signed [FREQ_W-1:0] clk_freq,
  output logic [WND_W-1:0]         wander_stat,
  output logic [ST_W-1:0]          status,
  output logic [CTR_W-1:0]         err_cnt,
  output logic [CTR_W-1:0]         wander_cnt
);
  localparam int MIN_EXP = 2;

  pulse_ev_t               ev;
  logic                    gap_ok;
  logic                    in_range;
  logic                    clamped;
  logic [EXP_W-1:0]        exp_q;
  logic [CNT_W-1:0]        start_q;
  logic [CNT_W-1:0]        prev_q;
  logic [CNT_W-1:0]        diff;
  logic signed [FREQ_W-1:0] freq_nxt;
  logic [WND_W-1:0]        wander_nxt;

  assign diff = cnt_sample - start_q;

  pps_gap_check #(
    .CNT_W(CNT_W), .NOM_TICKS(NOM_TICKS), .GAP_TOL(GAP_TOL)
  ) u_gap (
    .cur(cnt_sample), .prev(prev_q), .gap_ok(gap_ok)
  );

  pps_interval_ctl #(
    .CNT_W(CNT_W), .EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP)
  ) u_ivl (
    .clk(clk), .rst(rst), .pulse_vld(pulse_vld), .sample(cnt_sample),
    .gap_ok(gap_ok), .accept(in_range), .max_exp(max_exp),
    .ev(ev), .exp_q(exp_q), .start_q(start_q), .prev_q(prev_q)
  );

  pps_freq_step #(
    .CNT_W(CNT_W), .EXP_W(EXP_W), .FREQ_W(FREQ_W), .WND_W(WND_W),
    .NOM_TICKS(NOM_TICKS), .RANGE_TICKS(RANGE_TICKS), .STEP_MAX(STEP_MAX)
  ) u_step (
    .diff(diff), .exp_k(exp_q), .freq(pps_freq), .wander(wander_stat),
    .in_range(in_range), .clamped(clamped),
    .freq_nxt(freq_nxt), .wander_nxt(wander_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_freq    <= '0;
      wander_stat <= '0;
      status      <= '0;
      err_cnt     <= '0;
      wander_cnt  <= '0;
    end else if (ev != EV_IDLE) begin
      status <= '0;
      if (ev == EV_GAP_ERR) begin
        status[ST_GAP] <= 1'b1;
        err_cnt        <= err_cnt + CTR_W'(1);
      end else if (ev == EV_CLOSE) begin
        if (!in_range) begin
          status[ST_RNG] <= 1'b1;
          err_cnt        <= err_cnt + CTR_W'(1);
        end else begin
          pps_freq    <= freq_nxt;
          wander_stat <= wander_nxt;
          if (clamped) begin
            status[ST_CLP] <= 1'b1;
            wander_cnt     <= wander_cnt + CTR_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_freq <= '0;
    else     clk_freq <= freq_en ? pps_freq : '0;
  end
endmodule

// File: rtl/pps_freq_cal_chk.sv
module pps_freq_cal_chk #(
  parameter int FREQ_W   = 16,
  parameter int WND_W    = 8,
  parameter int CTR_W    = 8,
  parameter int STEP_MAX = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     pulse_vld,
  input logic                     freq_en,
  input logic signed [FREQ_W-1:0] pps_freq,
  input logic signed [FREQ_W-1:0] clk_freq,
  input logic [WND_W-1:0]         wander_stat,
  input logic [2:0]               status,
  input logic [CTR_W-1:0]         err_cnt,
  input logic [CTR_W-1:0]         wander_cnt
);
  // R5
  err_bump_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_vld) && (status[0] || status[1])) |->
      (err_cnt == CTR_W'($past(err_cnt) + 1)));

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (($signed(pps_freq) - $signed($past(pps_freq))) <= STEP_MAX) &&
    (($signed(pps_freq) - $signed($past(pps_freq))) >= -STEP_MAX));

  // R7
  clamp_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_vld) && status[2]) |->
      (wander_cnt == CTR_W'($past(wander_cnt) + 1)));

  // R8
  wander_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(wander_stat) <= STEP_MAX));

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(freq_en) |-> (clk_freq == '0));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pulse_vld) |-> ($stable(status) && $stable(err_cnt) &&
                           $stable(wander_cnt) && $stable(pps_freq)));
endmodule

bind pps_freq_cal pps_freq_cal_chk #(
  .FREQ_W(FREQ_W), .WND_W(WND_W), .CTR_W(CTR_W), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk(clk), .rst(rst), .pulse_vld(pulse_vld), .freq_en(freq_en),
  .pps_freq(pps_freq), .clk_freq(clk_freq), .wander_stat(wander_stat),
  .status(status), .err_cnt(err_cnt), .wander_cnt(wander_cnt)
);

// File: tb/pps_freq_cal_bench.sv
module pps_freq_cal_bench;
  localparam int CNT_W = 16, FREQ_W = 16, WND_W = 8, CTR_W = 8;
  localparam int NOM = 1000, GTOL = 100, RNG = 50, CLP = 10, MAXE = 5;
  localparam int EXP_W = 3;

  logic clk = 1'b0, rst = 1'b1, pulse_vld = 1'b0, freq_en = 1'b0;
  logic [CNT_W-1:0] cnt_sample = '0;
  logic [EXP_W-1:0] max_exp = 3'd5;
  logic signed [FREQ_W-1:0] pps_freq, clk_freq;
  logic [WND_W-1:0] wander_stat;
  logic [2:0] status;
  logic [CTR_W-1:0] err_cnt, wander_cnt;

  always #5 clk = ~clk;

  pps_freq_cal u_pps_freq_cal (
    .clk(clk), .rst(rst), .pulse_vld(pulse_vld), .cnt_sample(cnt_sample),
    .max_exp(max_exp), .freq_en(freq_en), .pps_freq(pps_freq),
    .clk_freq(clk_freq), .wander_stat(wander_stat), .status(status),
    .err_cnt(err_cnt), .wander_cnt(wander_cnt)
  );

  typedef struct packed {
    logic [15:0] gap;
    logic [7:0]  npulse;
    logic [2:0]  mexp;
    logic        en;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{16'd1000, 8'd1,  3'd5, 1'b0},  // arm only (R2)
    '{16'd1003, 8'd4,  3'd5, 1'b0},  // first 4-pulse interval, wraps (R3)
    '{16'd1020, 8'd8,  3'd5, 1'b0},  // big step, clamp (R7)
    '{16'd1020, 8'd16, 3'd5, 1'b0},
    '{16'd990,  8'd32, 3'd5, 1'b1},  // longest interval (R4)
    '{16'd1250, 8'd1,  3'd5, 1'b1},  // spacing error (R5)
    '{16'd1060, 8'd4,  3'd5, 1'b1},  // range error (R6)
    '{16'd1000, 8'd4,  3'd3, 1'b1},
    '{16'd1000, 8'd8,  3'd3, 1'b1},  // capped at 3
    '{16'd1000, 8'd8,  3'd0, 1'b0},  // cap floor 2
    '{16'd940,  8'd4,  3'd0, 1'b1},  // negative range error
    '{16'd955,  8'd4,  3'd7, 1'b1},  // negative clamp
    '{16'd1000, 8'd2,  3'd7, 1'b1},
    '{16'd2000, 8'd1,  3'd7, 1'b1},  // dropped pulse (R5)
    '{16'd1005, 8'd8,  3'd7, 1'b1}
  };

  int nchk = 0, nfail = 0;
  bit done = 0;
  int cur = 0;

  // reference model state
  bit m_arm;
  int m_prev, m_start, m_cnt, m_exp, m_freq, m_wand, m_err, m_wcnt, m_stat, m_en;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_arm = 0; m_prev = 0; m_start = 0; m_cnt = 0; m_exp = 2;
    m_freq = 0; m_wand = 0; m_err = 0; m_wcnt = 0; m_stat = 0;
  endtask

  task automatic m_pulse(input int s, input int mx);
    int gap, cap, diff, meas, stp, a;
    m_stat = 0;
    if (!m_arm) begin
      m_arm = 1; m_prev = s; m_start = s; m_cnt = 0; m_exp = 2;
      return;
    end
    gap = (s - m_prev) & 16'hFFFF;
    m_prev = s;
    if (gap < NOM - GTOL || gap > NOM + GTOL) begin
      m_stat = 1; m_err = (m_err + 1) & 8'hFF;
      m_start = s; m_cnt = 0; m_exp = 2;
      return;
    end
    m_cnt++;
    if (m_cnt != (1 << m_exp)) return;
    diff = (s - m_start) & 16'hFFFF;
    meas = (diff >> m_exp) - NOM;
    m_start = s; m_cnt = 0;
    if (meas > RNG || meas < -RNG) begin
      m_stat = 2; m_err = (m_err + 1) & 8'hFF; m_exp = 2;
      return;
    end
    stp = meas - m_freq;
    if (stp > CLP) begin stp = CLP; m_stat = 4; m_wcnt = (m_wcnt + 1) & 8'hFF; end
    else if (stp < -CLP) begin stp = -CLP; m_stat = 4; m_wcnt = (m_wcnt + 1) & 8'hFF; end
    m_freq += stp;
    a = (stp < 0) ? -stp : stp;
    if (a >= m_wand) m_wand = m_wand + ((a - m_wand) >> 2);
    else             m_wand = m_wand - ((m_wand - a) >> 2);
    cap = (mx < 2) ? 2 : ((mx > MAXE) ? MAXE : mx);
    m_exp = (m_exp >= cap) ? cap : m_exp + 1;
  endtask

  task automatic check_all(input string tag);
    chk({"R3/R4 pps_freq ", tag}, "pps_freq", int'(pps_freq), m_freq);
    chk({"R9 clk_freq ", tag}, "clk_freq", int'(clk_freq), m_en ? m_freq : 0);
    chk({"R8 wander ", tag}, "wander_stat", int'(wander_stat), m_wand);
    chk({"R10 status ", tag}, "status", int'(status), m_stat);
    chk({"R5/R6 err_cnt ", tag}, "err_cnt", int'(err_cnt), m_err);
    chk({"R7 wander_cnt ", tag}, "wander_cnt", int'(wander_cnt), m_wcnt);
  endtask

  task automatic pulse(input int gap, input string tag);
    cur = (cur + gap) & 16'hFFFF;
    @(negedge clk);
    cnt_sample = CNT_W'(cur);
    pulse_vld = 1'b1;
    @(negedge clk);
    pulse_vld = 1'b0;
    m_pulse(cur, int'(max_exp));
    @(negedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    m_reset();
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pps_freq", int'(pps_freq), 0);
    chk("R1", "clk_freq", int'(clk_freq), 0);
    chk("R1", "wander_stat", int'(wander_stat), 0);
    chk("R1", "status", int'(status), 0);
    chk("R1", "err_cnt", int'(err_cnt), 0);
    chk("R1", "wander_cnt", int'(wander_cnt), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    m_en = 0;
    cur = 16'hF000;
    do_reset();

    for (int v = 0; v < NV; v++) begin
      max_exp = VECS[v].mexp;
      freq_en = VECS[v].en;
      m_en = VECS[v].en;
      for (int p = 0; p < int'(VECS[v].npulse); p++)
        pulse(int'(VECS[v].gap), $sformatf("vec%0d", v));
    end

    // R10: idle stretch leaves everything untouched
    repeat (12) @(negedge clk);
    check_all("idle R10");

    // R9: gate off then on without pulses
    freq_en = 1'b0; m_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 gate off", "clk_freq", int'(clk_freq), 0);
    freq_en = 1'b1; m_en = 1;
    repeat (2) @(negedge clk);
    chk("R9 gate on", "clk_freq", int'(clk_freq), m_freq);

    // R1/R2: reset mid-run, then first pulse only arms
    do_reset();
    pulse(1000, "R2 arm");
    chk("R2 after arm", "pps_freq", int'(pps_freq), 0);
    for (int p = 0; p < 4; p++) pulse(1007, "post-reset R3");
    chk("R3 post-reset meas", "pps_freq", int'(pps_freq), 7);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule